// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block gathers the interrupt causes of a small switch-class device into one 32-bit status word and raises a single level interrupt request toward the host processor. Status bits come in two kinds. Three bits are sticky events: a software-raised interrupt, a device-ready event and a general-purpose timer wrap. Software acknowledges these by writing a one to the bit. The other four bits are live, read-only copies of interrupt lines from sub-blocks: the switch fabric, the two PHYs and the GPIO unit. Software clears those at the sub-block itself, and the copy follows the line.

A 32-bit enable word with the same layout masks the status into the request output. Status is always recorded, whether or not its cause is enabled. Setting the software-interrupt enable bit raises the software interrupt itself. The block also holds a down-counting timer that reloads to all ones after reaching zero and flags the wrap as an event.

All access uses a simple select/write/address bus. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge. Register offsets: status 058h, enable 05Ch, timer control 060h (bit 0 = run), timer count 064h (a write loads the count).

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word, the enable word and the run bit are zero, `irq_o` is low, and the timer count reads FFFFh.
- R2: Status bits 29, 25:20, 18:13 and 11:0 always read 0. An enable write keeps only bits 31, 30, 28, 27, 26, 19 and 12, and all other enable bits read 0.
- R3: Status bits 28, 27, 26 and 12 show `fabric_irq_i`, `phy2_irq_i`, `phy1_irq_i` and `gpio_irq_i` one clock after they are sampled. Writing ones to these bits has no effect on them.
- R4: Every status bit records its cause whatever the value of the matching enable bit.
- R5: Writing 1 to status bit 31, 30 or 19 clears that bit. Writing 0 to a status bit leaves it unchanged.
- R6: Status bit 31 becomes set in the cycle an enable write changes enable bit 31 from 0 to 1. An enable bit 31 that stays set does not set the bit again.
- R7: Status bit 30 becomes set one clock after `ready_i` rises. A `ready_i` that stays high does not set it again.
- R8: While the run bit is 1, the timer count decreases by one every PRESCALE clocks, first PRESCALE clocks after the run write. While the run bit is 0 the count holds.
- R9: A timer tick at count 0 reloads the count to FFFFh and sets status bit 19 one clock later.
- R10: When an event and a clear write hit the same sticky bit in the same cycle, the bit stays set.
- R11: `irq_o` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| fabric_irq_i | input | 1 | Switch fabric interrupt line |
| phy2_irq_i | input | 1 | Port-2 PHY interrupt line |
| phy1_irq_i | input | 1 | Port-1 PHY interrupt line |
| gpio_irq_i | input | 1 | Aggregated GPIO interrupt line |
| ready_i | input | 1 | Device-ready level from power-up sequencing |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The hardest case to produce is a sticky event and its acknowledge in the same clock, because the two come from independent paths. The bench drops `ready_i` for a cycle, then raises it on the same falling edge that starts a write-one-to-clear of bit 30, so that edge detection and the clear land on one rising edge. The timer wrap needs exact cycle counting: the bench loads a count of 1 and counts falling edges from the run write, so that it reads the reload value and the new status bit in the window before the next decrement. The live lines and their enables are swept exhaustively, 256 combinations, against a request computed in the bench.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W = 32;

    // status / enable bit positions
    localparam int BIT_SW   = 31;
    localparam int BIT_RDY  = 30;
    localparam int BIT_FAB  = 28;
    localparam int BIT_PHY2 = 27;
    localparam int BIT_PHY1 = 26;
    localparam int BIT_GPT  = 19;
    localparam int BIT_GPIO = 12;

    localparam logic [REG_W-1:0] DEF_MASK =
        (32'h1 << BIT_SW)   | (32'h1 << BIT_RDY)  | (32'h1 << BIT_FAB) |
        (32'h1 << BIT_PHY2) | (32'h1 << BIT_PHY1) | (32'h1 << BIT_GPT) |
        (32'h1 << BIT_GPIO);

    // register offsets
    localparam logic [11:0] OFS_STAT = 12'h058;
    localparam logic [11:0] OFS_EN   = 12'h05C;
    localparam logic [11:0] OFS_TCTL = 12'h060;
    localparam logic [11:0] OFS_TCNT = 12'h064;

    // sticky event slots
    localparam int NSTICKY = 3;
    localparam int STK_SW  = 0;
    localparam int STK_RDY = 1;
    localparam int STK_GPT = 2;
    localparam int NLIVE   = 4;

    function automatic int stk_pos(input int idx);
        case (idx)
            STK_SW:  return BIT_SW;
            STK_RDY: return BIT_RDY;
            default: return BIT_GPT;
        endcase
    endfunction

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic             run;
        logic [NLIVE-1:0] live;   // {fabric, phy2, phy1, gpio}
        logic             rdy_prev;
    } agg_state_t;

endpackage

// File: rtl/irq_gp_timer.sv
module irq_gp_timer #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             wrap;
    } tmr_state_t;

    tmr_state_t t_d, t_q;
    logic       tick;

    always_comb begin
        t_d      = t_q;
        t_d.wrap = 1'b0;
        tick     = run_i && (t_q.pre == PRE_LAST);
        if (load_i) begin
            t_d.cnt = load_val_i;
            t_d.pre = '0;
        end else if (!run_i) begin
            t_d.pre = '0;
        end else if (tick) begin
            t_d.pre = '0;
            if (t_q.cnt == '0) begin
                t_d.cnt  = '1;
                t_d.wrap = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else begin
            t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt  <= '1;
            t_q.pre  <= '0;
            t_q.wrap <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt_o  = t_q.cnt;
    assign wrap_o = t_q.wrap;
endmodule

// File: rtl/irq_sticky_bits.sv
module irq_sticky_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q_d, q_q;

    // a new event beats an acknowledge in the same cycle
    always_comb begin
        for (int i = 0; i < N; i++) begin
            q_d[i] = set_i[i] | (q_q[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              fabric_irq_i,
    input  logic              phy2_irq_i,
    input  logic              phy1_irq_i,
    input  logic              gpio_irq_i,
    input  logic              ready_i,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_TCTL = ADDR_W'(OFS_TCTL);
    localparam logic [ADDR_W-1:0] A_TCNT = ADDR_W'(OFS_TCNT);

    agg_state_t s_d, s_q;

    logic               wr_stat, wr_en, wr_tctl, wr_tcnt, rd;
    logic [NSTICKY-1:0] stk_set, stk_clr, stk_q;
    logic [CNT_W-1:0]   tmr_cnt;
    logic               tmr_wrap;
    logic [REG_W-1:0]   status_w;
    logic               rdy_prev_w;
    logic               run_w;
    logic [REG_W-1:0]   en_w;

    // bus decode
    always_comb begin
        rd      = bus_sel && !bus_wr;
        wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
        wr_en   = bus_sel && bus_wr && (bus_addr == A_EN);
        wr_tctl = bus_sel && bus_wr && (bus_addr == A_TCTL);
        wr_tcnt = bus_sel && bus_wr && (bus_addr == A_TCNT);
    end

    // next-state for control state
    always_comb begin
        s_d          = s_q;
        if (wr_en)   s_d.en  = bus_wdata & DEF_MASK;
        if (wr_tctl) s_d.run = bus_wdata[0];
        s_d.live     = {fabric_irq_i, phy2_irq_i, phy1_irq_i, gpio_irq_i};
        s_d.rdy_prev = ready_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // sticky event sources and acknowledges
    always_comb begin
        stk_set          = '0;
        stk_set[STK_SW]  = wr_en && bus_wdata[BIT_SW] && !s_q.en[BIT_SW];
        stk_set[STK_RDY] = ready_i && !s_q.rdy_prev;
        stk_set[STK_GPT] = tmr_wrap;
    end

    for (genvar g = 0; g < NSTICKY; g++) begin : g_clr
        assign stk_clr[g] = wr_stat && bus_wdata[stk_pos(g)];
    end

    irq_sticky_bits #(.N(NSTICKY)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (stk_set),
        .clr_i (stk_clr),
        .q_o   (stk_q)
    );

    irq_gp_timer #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (s_q.run),
        .load_i     (wr_tcnt),
        .load_val_i (bus_wdata[CNT_W-1:0]),
        .cnt_o      (tmr_cnt),
        .wrap_o     (tmr_wrap)
    );

    // status word assembly
    always_comb begin
        status_w           = '0;
        status_w[BIT_SW]   = stk_q[STK_SW];
        status_w[BIT_RDY]  = stk_q[STK_RDY];
        status_w[BIT_GPT]  = stk_q[STK_GPT];
        status_w[BIT_FAB]  = s_q.live[3];
        status_w[BIT_PHY2] = s_q.live[2];
        status_w[BIT_PHY1] = s_q.live[1];
        status_w[BIT_GPIO] = s_q.live[0];
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (bus_addr == A_STAT)      bus_rdata = status_w;
            else if (bus_addr == A_EN)   bus_rdata = s_q.en;
            else if (bus_addr == A_TCTL) bus_rdata = {{(REG_W-1){1'b0}}, s_q.run};
            else if (bus_addr == A_TCNT) bus_rdata = REG_W'(tmr_cnt);
        end
    end

    assign irq_o      = |(status_w & s_q.en);
    assign rdy_prev_w = s_q.rdy_prev;
    assign run_w      = s_q.run;
    assign en_w       = s_q.en;
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              fabric_irq_i,
    input logic              ready_i,
    input logic              irq_o,
    input logic [REG_W-1:0]  status_w,
    input logic [REG_W-1:0]  en_w,
    input logic              rdy_prev_w,
    input logic              run_w,
    input logic [CNT_W-1:0]  tmr_cnt,
    input logic              tmr_wrap
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_TCNT = ADDR_W'(OFS_TCNT);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_STAT) |-> ((bus_rdata & ~DEF_MASK) == '0));

    // R3
    live_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fabric_irq_i |=> status_w[BIT_FAB]);

    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_STAT && bus_wdata[BIT_SW]) |=> !status_w[BIT_SW]);

    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !rdy_prev_w && bus_sel && bus_wr && bus_addr == A_STAT && bus_wdata[BIT_RDY])
        |=> status_w[BIT_RDY]);

    // R9
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |-> (tmr_cnt == '1));

    // R9
    wrap_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |=> status_w[BIT_GPT]);

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !(bus_sel && bus_wr && bus_addr == A_TCNT)) |=> $stable(tmr_cnt));

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_w != '0 && en_w != '0));
endmodule

bind irq_status_agg irq_status_agg_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .fabric_irq_i (fabric_irq_i),
    .ready_i      (ready_i),
    .irq_o        (irq_o),
    .status_w     (status_w),
    .en_w         (en_w),
    .rdy_prev_w   (rdy_prev_w),
    .run_w        (run_w),
    .tmr_cnt      (tmr_cnt),
    .tmr_wrap     (tmr_wrap)
);

// File: tb/irq_status_agg_bench.sv
`timescale 1ns/1ps
module irq_status_agg_bench;
    localparam int ADDR_W = 8;
    localparam logic [7:0] A_STAT = 8'h58;
    localparam logic [7:0] A_EN   = 8'h5C;
    localparam logic [7:0] A_TCTL = 8'h60;
    localparam logic [7:0] A_TCNT = 8'h64;
    localparam logic [31:0] MASK  = 32'hDC08_1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              fabric_irq_i = 1'b0;
    logic              phy2_irq_i = 1'b0;
    logic              phy1_irq_i = 1'b0;
    logic              gpio_irq_i = 1'b0;
    logic              ready_i = 1'b0;
    logic              irq_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    irq_status_agg u_irq_status_agg (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .fabric_irq_i (fabric_irq_i),
        .phy2_irq_i   (phy2_irq_i),
        .phy1_irq_i   (phy1_irq_i),
        .gpio_irq_i   (gpio_irq_i),
        .ready_i      (ready_i),
        .irq_o        (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called on a falling edge; consumes exactly one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // combinational read, consumes no edge
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] live_map(input logic [3:0] v);
        logic [31:0] m = '0;
        m[28] = v[3]; m[27] = v[2]; m[26] = v[1]; m[12] = v[0];
        return m;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: got %0d cycles expected < 100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_STAT, rv); chk("R1 status", rv, 32'h0);
        rd(A_EN, rv);   chk("R1 enable", rv, 32'h0);
        rd(A_TCTL, rv); chk("R1 run", rv, 32'h0);
        rd(A_TCNT, rv); chk("R1 count", rv, 32'h0000_FFFF);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 enable keeps only defined bits; R6 software interrupt on 0->1
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, rv);   chk("R2 enable mask", rv, MASK);
        rd(A_STAT, rv); chk("R6 sw set", rv, 32'h8000_0000);
        chk("R11 irq sw", {31'b0, irq_o}, 32'h1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); chk("R5 write zero", rv, 32'h8000_0000);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, rv); chk("R5 clear sw", rv, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_STAT, rv); chk("R6 no re-set while held", rv, 32'h0);
        wr(A_EN, 32'h0);

        // R3 R11 R4 exhaustive sweep of live lines against their enables
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 16; e++) begin
                wr(A_EN, live_map(4'(e)));
                {fabric_irq_i, phy2_irq_i, phy1_irq_i, gpio_irq_i} = 4'(v);
                @(negedge clk);
                rd(A_STAT, rv); chk("R3 R4 live status", rv, live_map(4'(v)));
                chk("R11 irq live", {31'b0, irq_o}, {31'b0, |(v & e)});
            end
        end
        // R3 writing ones to live bits changes nothing; R2 reserved stay zero
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, rv); chk("R3 R2 live after w1", rv, live_map(4'hF));
        {fabric_irq_i, phy2_irq_i, phy1_irq_i, gpio_irq_i} = 4'h0;
        wr(A_EN, 32'h0);
        @(negedge clk);

        // R7 ready edge sets bit 30 once
        ready_i = 1'b1;
        @(negedge clk);
        rd(A_STAT, rv); chk("R7 ready set", rv, 32'h4000_0000);
        chk("R4 irq masked", {31'b0, irq_o}, 32'h0);
        wr(A_STAT, 32'h4000_0000);
        repeat (3) @(negedge clk);
        rd(A_STAT, rv); chk("R7 level no re-set", rv, 32'h0);

        // R10 event and acknowledge in the same cycle
        ready_i = 1'b0;
        @(negedge clk);
        ready_i = 1'b1;
        wr(A_STAT, 32'h4000_0000);
        rd(A_STAT, rv); chk("R10 event wins", rv, 32'h4000_0000);
        wr(A_STAT, 32'h4000_0000);
        rd(A_STAT, rv); chk("R5 clear ready", rv, 32'h0);

        // R8 prescaled decrement and hold
        wr(A_TCNT, 32'd10);
        wr(A_TCTL, 32'd1);
        repeat (9) @(negedge clk);
        rd(A_TCNT, rv); chk("R8 two ticks", rv, 32'd8);
        wr(A_TCTL, 32'd0);
        repeat (20) @(negedge clk);
        rd(A_TCNT, rv); chk("R8 hold stopped", rv, 32'd8);

        // R9 wrap from zero
        wr(A_TCNT, 32'd1);
        wr(A_TCTL, 32'd1);
        repeat (10) @(negedge clk);
        rd(A_TCNT, rv); chk("R9 reload", rv, 32'h0000_FFFF);
        rd(A_STAT, rv); chk("R9 wrap event", rv, 32'h0008_0000);
        wr(A_TCTL, 32'd0);
        wr(A_EN, 32'h0008_0000);
        chk("R11 irq timer", {31'b0, irq_o}, 32'h1);
        wr(A_STAT, 32'h0008_0000);
        rd(A_STAT, rv); chk("R5 clear timer", rv, 32'h0);
        chk("R11 irq low", {31'b0, irq_o}, 32'h0);

        finish_run();
    end
endmodule